// File: doc/BRIEF.md
# Serial Register Bank with Prefix-Coded Addressing

This block is the configuration front end of a synthesizer controller. A host writes 24-bit words over three wires: a serial clock, a data line and a latch enable. The wires are asynchronous to the block clock, so they are synchronized first. On each rising serial clock edge while latch enable is low, one data bit enters a 24-bit shift register, most significant bit first. A rising edge on latch enable copies the assembled word into one of six control registers.

The target register comes from a variable-length address code in the low bits of the word. No code is a prefix of another, so the decode is unambiguous. Four registers drive general control fields at the outputs. The other two hold a user-chosen IF feedback divider and a user-chosen IF reference divider. A mode bit in register 0 chooses what the IF divider outputs show: built-in default divider values, or the two user registers. A reference divider loaded below its legal minimum is raised to that minimum at the output.

Top module: `cfg_serial_bank`

## Requirements
- R1: After reset every control register holds zero, so `if_user_o` is 0, all `ctl_*` outputs are 0, and the IF divider outputs carry the defaults `DEF_IF_N` and `DEF_IF_R`.
- R2: While register 0 bit 2 (the mode bit) is 0, `if_n_o` equals `DEF_IF_N` and `if_r_o` equals `DEF_IF_R`, whatever registers 4 and 5 hold.
- R3: Each rising serial clock edge with latch enable low shifts the data bit into bit 0 and moves the older bits up, so the word is sent most significant bit first. Only the last 24 bits received are kept.
- R4: The word's low bits select the register: [1:0]=00 is register 0, [1:0]=01 is register 1, [1:0]=10 is register 2, [2:0]=011 is register 3, [3:0]=0111 is register 4, [4:0]=01111 is register 5. A word with [4:0]=11111 writes no register.
- R5: A register is written only on a rising edge of latch enable. Each latch writes at most the one decoded register and leaves all the others unchanged.
- R6: Serial clock edges that occur while latch enable is high do not shift the register.
- R7: While the mode bit is 1, `if_n_o` equals register 4 bits [19:4] and `if_r_o` equals register 5 bits [13:5].
- R8: In user mode, a register 5 reference value of 0 or 1 drives `if_r_o` to 2. Values from 2 to 511 pass through unchanged.
- R9: The `ctl_r0_o`, `ctl_r1_o` and `ctl_r2_o` outputs show bits [23:2] of registers 0, 1 and 2. `ctl_r3_o` shows bits [23:3] of register 3. `if_user_o` shows the mode bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, asynchronous |
| ser_le_i | input | 1 | Latch enable, asynchronous |
| ctl_r0_o | output | 22 | Register 0 bits [23:2] |
| ctl_r1_o | output | 22 | Register 1 bits [23:2] |
| ctl_r2_o | output | 22 | Register 2 bits [23:2] |
| ctl_r3_o | output | 21 | Register 3 bits [23:3] |
| if_user_o | output | 1 | Mode bit: 1 = user IF dividers |
| if_n_o | output | 16 | IF feedback divider in effect |
| if_r_o | output | 9 | IF reference divider in effect |

## Verification
A fault in the shift register or the address decode sends a word to the wrong register. That shows up within a few clocks of the latch edge: one control output changes when it should not, or the intended one stays put. This is why every latch is followed by a comparison of all outputs at once. A shift that leaks while latch enable is high stays hidden until the next latch. That latch then lands in an unexpected register, so the bench latches again without sending new bits. A wrong mode or clamp path shows at once on the IF divider outputs, since they are combinational views of the stored registers.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;
    localparam int WORD_W   = 24;
    localparam int NUM_REGS = 6;
    localparam int CODE_W   = NUM_REGS - 1;   // longest address code
    localparam int SYNC_CH  = 3;

    // channel indices inside the synchronizer
    localparam int CH_SCLK = 0;
    localparam int CH_SDAT = 1;
    localparam int CH_SLE  = 2;

    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/cfg_edge_sync.sv
module cfg_edge_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] rise_o
);
    // per channel: STAGES synchronizer flops plus one history flop
    logic [N-1:0][STAGES:0] chain_d, chain_q;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            chain_d[i] = {chain_q[i][STAGES-1:0], async_i[i]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_ch
        assign lvl_o[g]  = chain_q[g][STAGES-1];
        assign rise_o[g] = chain_q[g][STAGES-1] & ~chain_q[g][STAGES];
    end
endmodule

// File: rtl/cfg_shift_reg.sv
module cfg_shift_reg #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_i,
    output logic [W-1:0] word_o
);
    logic [W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (shift_en) sr_d = {sr_q[W-2:0], bit_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign word_o = sr_q;
endmodule

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode #(
    parameter int NREG = 6
) (
    input  logic [NREG-2:0] code_i,
    output logic [NREG-1:0] sel_o
);
    // two-bit codes 00, 01, 10 pick registers 0..2
    assign sel_o[0] = (code_i[1:0] == 2'b00);
    assign sel_o[1] = (code_i[1:0] == 2'b01);
    assign sel_o[2] = (code_i[1:0] == 2'b10);

    // longer codes: a run of (k-1) ones ended by a zero picks register k
    for (genvar k = 3; k < NREG; k++) begin : g_long
        assign sel_o[k] = (&code_i[k-2:0]) & ~code_i[k-1];
    end
endmodule

// File: rtl/cfg_serial_bank.sv
module cfg_serial_bank
    import cfg_bank_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter int          MODE_BIT    = 2,
    parameter int          IF_N_W      = 16,
    parameter int          IF_N_LSB    = 4,
    parameter int          IF_R_W      = 9,
    parameter int          IF_R_LSB    = 5,
    parameter int          IF_R_MIN    = 2,
    parameter logic [15:0] DEF_IF_N    = 16'd2296,
    parameter logic [8:0]  DEF_IF_R    = 9'd48
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ser_clk_i,
    input  logic                ser_dat_i,
    input  logic                ser_le_i,
    output logic [WORD_W-3:0]   ctl_r0_o,
    output logic [WORD_W-3:0]   ctl_r1_o,
    output logic [WORD_W-3:0]   ctl_r2_o,
    output logic [WORD_W-4:0]   ctl_r3_o,
    output logic                if_user_o,
    output logic [IF_N_W-1:0]   if_n_o,
    output logic [IF_R_W-1:0]   if_r_o
);
    localparam int REG_IF_N = 4;
    localparam int REG_IF_R = 5;

    typedef struct packed {
        logic [NUM_REGS-1:0][WORD_W-1:0] r;
    } bank_t;

    logic [SYNC_CH-1:0]  lvl, rise;
    logic                le_rise, shift_en;
    word_t               word;
    logic [NUM_REGS-1:0] wr_sel;
    bank_t               bank_d, bank_q;

    cfg_edge_sync #(.N(SYNC_CH), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({ser_le_i, ser_dat_i, ser_clk_i}),
        .lvl_o  (lvl),
        .rise_o (rise)
    );

    assign le_rise  = rise[CH_SLE];
    assign shift_en = rise[CH_SCLK] & ~lvl[CH_SLE];

    cfg_shift_reg #(.W(WORD_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(shift_en),
        .bit_i   (lvl[CH_SDAT]),
        .word_o  (word)
    );

    cfg_addr_decode #(.NREG(NUM_REGS)) u_dec (
        .code_i(word[CODE_W-1:0]),
        .sel_o (wr_sel)
    );

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (le_rise && wr_sel[i]) bank_d.r[i] = word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    logic [IF_R_W-1:0] user_r;

    always_comb begin
        user_r    = bank_q.r[REG_IF_R][IF_R_LSB +: IF_R_W];
        if_user_o = bank_q.r[0][MODE_BIT];
        if (if_user_o) begin
            if_n_o = bank_q.r[REG_IF_N][IF_N_LSB +: IF_N_W];
            if_r_o = (user_r < IF_R_W'(IF_R_MIN)) ? IF_R_W'(IF_R_MIN) : user_r;
        end else begin
            if_n_o = DEF_IF_N;
            if_r_o = DEF_IF_R;
        end
    end

    assign ctl_r0_o = bank_q.r[0][WORD_W-1:2];
    assign ctl_r1_o = bank_q.r[1][WORD_W-1:2];
    assign ctl_r2_o = bank_q.r[2][WORD_W-1:2];
    assign ctl_r3_o = bank_q.r[3][WORD_W-1:3];

    logic sig_unused;
    assign sig_unused = ^{lvl[CH_SCLK], rise[CH_SDAT], bank_q.r[0][1:0],
                          bank_q.r[1][1:0], bank_q.r[2][1:0], bank_q.r[3][2:0],
                          bank_q.r[REG_IF_N], bank_q.r[REG_IF_R]};
endmodule

// File: rtl/cfg_serial_bank_chk.sv
module cfg_serial_bank_chk #(
    parameter int          IF_N_W   = 16,
    parameter int          IF_R_W   = 9,
    parameter int          IF_R_MIN = 2,
    parameter int          NREG     = 6,
    parameter int          CTL_W    = 22,
    parameter logic [15:0] DEF_IF_N = 16'd2296,
    parameter logic [8:0]  DEF_IF_R = 9'd48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              le_rise,
    input logic [NREG-1:0]   sel,
    input logic [CTL_W-1:0]  c0,
    input logic [CTL_W-1:0]  c1,
    input logic [CTL_W-1:0]  c2,
    input logic [CTL_W-2:0]  c3,
    input logic              user,
    input logic [IF_N_W-1:0] if_n,
    input logic [IF_R_W-1:0] if_r
);
    // R4: the prefix code picks at most one register
    a_r4_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    // R5: without a latch edge no control output moves
    a_r5_hold_without_latch: assert property (@(posedge clk) disable iff (!rst_n)
        !le_rise |=> ($stable(c0) && $stable(c1) && $stable(c2) && $stable(c3)));

    // R5: a latch edge changes at most one control register
    a_r5_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        le_rise |=> ($countones({c0 != $past(c0), c1 != $past(c1),
                                 c2 != $past(c2), c3 != $past(c3)}) <= 1));

    // R2: default mode shows the built-in dividers
    a_r2_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        !user |-> (if_n == DEF_IF_N && if_r == DEF_IF_R));

    // R8: reference divider never below its minimum
    a_r8_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        if_r >= IF_R_W'(IF_R_MIN));
endmodule

bind cfg_serial_bank cfg_serial_bank_chk #(
    .IF_N_W  (IF_N_W),
    .IF_R_W  (IF_R_W),
    .IF_R_MIN(IF_R_MIN),
    .NREG    (cfg_bank_pkg::NUM_REGS),
    .CTL_W   (cfg_bank_pkg::WORD_W - 2),
    .DEF_IF_N(DEF_IF_N),
    .DEF_IF_R(DEF_IF_R)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .le_rise(le_rise),
    .sel    (wr_sel),
    .c0     (ctl_r0_o),
    .c1     (ctl_r1_o),
    .c2     (ctl_r2_o),
    .c3     (ctl_r3_o),
    .user   (if_user_o),
    .if_n   (if_n_o),
    .if_r   (if_r_o)
);

// File: tb/cfg_serial_bank_tb.sv
module cfg_serial_bank_tb;
    localparam logic [15:0] DEF_N = 16'd2296;
    localparam logic [8:0]  DEF_R = 9'd48;
    localparam int NVEC = 13;

    // stimulus words; expected results come from the bench model
    localparam logic [23:0] VEC [NVEC] = '{
        24'hABCDE1,   // R1 target
        24'h123450,   // R0, mode 0
        24'h55AA56,   // R2 target
        24'h0F0F03,   // R3 target
        24'h0ABC07,   // R4 target, still defaults (R2)
        24'h000C8F,   // R5 value 100, still defaults (R2)
        24'h000004,   // R0 mode 1 -> user values (R7)
        24'h00002F,   // R5 value 1 -> clamp (R8)
        24'h00000F,   // R5 value 0 -> clamp (R8)
        24'h003FEF,   // R5 value 511
        24'hFFFFFF,   // code 11111: no write (R4)
        24'h7654A7,   // R4 new value in user mode (R7)
        24'h000000    // back to defaults (R2)
    };

    logic clk = 0, rst_n = 0;
    logic sclk = 0, sdat = 0, sle = 0;
    logic [21:0] ctl0, ctl1, ctl2;
    logic [20:0] ctl3;
    logic        user;
    logic [15:0] ifn;
    logic [8:0]  ifr;

    int tests = 0, fails = 0;
    logic [23:0] model [6];
    logic [23:0] sent;

    always #2 clk = ~clk;   // 250 MHz

    cfg_serial_bank u_dut (
        .clk(clk), .rst_n(rst_n),
        .ser_clk_i(sclk), .ser_dat_i(sdat), .ser_le_i(sle),
        .ctl_r0_o(ctl0), .ctl_r1_o(ctl1), .ctl_r2_o(ctl2), .ctl_r3_o(ctl3),
        .if_user_o(user), .if_n_o(ifn), .if_r_o(ifr)
    );

    function automatic int target(input logic [23:0] w);
        if (w[1:0] == 2'b00) return 0;
        if (w[1:0] == 2'b01) return 1;
        if (w[1:0] == 2'b10) return 2;
        if (w[2] == 1'b0)    return 3;
        if (w[3] == 1'b0)    return 4;
        if (w[4] == 1'b0)    return 5;
        return -1;
    endfunction

    task automatic check_all(input string tag);
        logic        m_user;
        logic [15:0] e_n;
        logic [8:0]  e_r;
        bit          bad;
        m_user = model[0][2];
        e_n = m_user ? model[4][19:4] : DEF_N;
        e_r = m_user ? ((model[5][13:5] < 9'd2) ? 9'd2 : model[5][13:5]) : DEF_R;
        bad = (ctl0 !== model[0][23:2]) || (ctl1 !== model[1][23:2]) ||
              (ctl2 !== model[2][23:2]) || (ctl3 !== model[3][23:3]) ||
              (user !== m_user) || (ifn !== e_n) || (ifr !== e_r);
        tests++;
        if (bad) begin
            fails++;
            $display("FAIL %s: got c0=%h c1=%h c2=%h c3=%h u=%b n=%0d r=%0d exp c0=%h c1=%h c2=%h c3=%h u=%b n=%0d r=%0d",
                     tag, ctl0, ctl1, ctl2, ctl3, user, ifn, ifr,
                     model[0][23:2], model[1][23:2], model[2][23:2], model[3][23:3],
                     m_user, e_n, e_r);
        end
    endtask

    task automatic ser_bit(input logic b);
        sdat = b;
        repeat (4) @(negedge clk);
        sclk = 1;
        repeat (4) @(negedge clk);
        sclk = 0;
        repeat (4) @(negedge clk);
    endtask

    task automatic latch();
        sle = 1;
        repeat (6) @(negedge clk);
        sle = 0;
        repeat (6) @(negedge clk);
        if (target(sent) >= 0) model[target(sent)] = sent;
    endtask

    task automatic send_word(input logic [23:0] w);
        for (int i = 23; i >= 0; i--) ser_bit(w[i]);
        sent = w;
        latch();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 6; i++) model[i] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (4) @(negedge clk);
        check_all("R1 reset state");

        for (int v = 0; v < NVEC; v++) begin
            send_word(VEC[v]);
            check_all($sformatf("R2/R3/R4/R5/R7/R8/R9 vector %0d", v));
        end

        // R3: extra leading bits fall off the top of the shift register
        for (int i = 0; i < 6; i++) ser_bit(1'b1);
        send_word(24'h3C3C3E);
        check_all("R3 oldest bits discarded");

        // R6: clock edges with latch enable high are ignored
        send_word(24'h13579D);
        sle = 1;
        repeat (6) @(negedge clk);
        for (int i = 0; i < 8; i++) ser_bit(1'b0);
        sle = 0;
        repeat (6) @(negedge clk);
        latch();
        check_all("R6 edges during latch ignored");

        // R8 boundary: value 2 passes, in user mode
        send_word(24'h000004);
        send_word(24'h00004F);
        check_all("R8 minimum legal value");

        // R1: reset in mid-operation clears everything
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        for (int i = 0; i < 6; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        check_all("R1 reset after traffic");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule